// File: doc/BRIEF.md
# Sample Bus Pattern Checker with Alarm Gating

This block watches a parallel sample bus during link bring-up and reports bit errors. Software first loads eight expected sample words. The transmitter then sends those eight words in a loop and marks the first word of each loop with a frame pulse. The checker walks through its expected words in step with the incoming samples and compares each sample with the word for its slot.

Every mismatching bit sets a bit in a sticky per-bit error register. Any mismatch also sets a sticky pattern alarm in a status register. Software clears both registers by writing zero to them, lets traffic run, and then polls them. A mask bit and a separate output-enable bit decide whether the alarm also drives a registered interrupt-style output. All configuration goes through a plain address/data port with a write strobe and a read strobe.

Top module: `bus_pattern_monitor`

## Requirements
- R1: Expected keys 0 to 7 sit at addresses 0x8 to 0xF, key k at 0x8+k. Each key is written with a full-width word and reads back unchanged. Sample slot k is compared against the key at 0x8+k.
- R2: Comparison takes place only while CTRL (address 0x0) bit 0 is 1. While that bit is 0, samples never change the error or status registers. After the bit is set, nothing is compared until a frame pulse arrives.
- R3: A valid sample with the frame pulse high is compared against key 0. The valid samples after it use keys 1 to 7 in turn, and the sequence then wraps to key 0 without a new frame.
- R4: Each bit in which a compared sample differs from its key sets the same bit of the error register (address 0x3). That bit stays set until software clears it.
- R5: A write to the error register or to the status register (address 0x1) keeps only those set bits whose written bit is 1. Writing zero clears the register, and writing all ones leaves it unchanged.
- R6: Status bit 0 becomes 1 on any mismatch in a compared sample and stays 1 until it is cleared.
- R7: MASK (address 0x2) bit 0 resets to 1. While that bit is 1 the pattern alarm never reaches alarm_out, and the status register still reads back its true value.
- R8: alarm_out stays 0 while CTRL bit 1 is 0.
- R9: A frame pulse on any valid sample forces that sample to key 0, wherever the sequence was at that point.
- R10: If a mismatch and a clearing write to the error or status register fall in the same cycle, the bits from the mismatch are still set afterwards.
- R11: alarm_out is a register. It goes to 1 one clock after status bit 0 is 1 while MASK bit 0 is 0 and CTRL bit 1 is 1, and it falls one clock after any of these conditions stops holding.
- R12: rd_data is loaded on a clock with rd_en high and holds its value otherwise. Unused addresses and unused bits read as 0.
- R13: After reset, CTRL, status, the error register and all keys read 0, MASK reads 1, and alarm_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | SAMPLE_W (16) | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (4) | Register read address |
| rd_data | output | SAMPLE_W (16) | Registered read data |
| smp_valid | input | 1 | Incoming sample is valid |
| smp_frame | input | 1 | Marks the sample for key 0 |
| smp_data | input | SAMPLE_W (16) | Incoming sample word |
| alarm_out | output | 1 | Gated alarm output |

## Verification
The assertions check several rules on every cycle. Error bits never fall unless software writes the error register. Each mismatch leaves both its bits and the status alarm set. Nothing is compared while checking is off. alarm_out stays low while masked or disabled, and it only rises after an unmasked, enabled status alarm.

Some behaviours only the bench scenarios can show. These are the key order and the wrap after key 7, and resynchronisation on a frame pulse in the middle of a sequence. The bench also covers the silent period between enabling and the first frame, the per-bit effect of clearing writes, an error and a clear in the same cycle, and the exact one-cycle delay of alarm_out.

// File: rtl/pbm_pkg.sv
// Package: shared register addresses and control bit positions for the
// sample bus pattern checker. Assumes a register address space of at least
// 16 words so that the key window fits above the control registers.
package pbm_pkg;
    localparam int REG_CTRL     = 0;
    localparam int REG_STATUS   = 1;
    localparam int REG_MASK     = 2;
    localparam int REG_BITERR   = 3;
    localparam int KEY_BASE     = 8;
    localparam int CTRL_CHK_BIT = 0;
    localparam int CTRL_ALM_BIT = 1;
endpackage

// File: rtl/pbm_regs.sv
// Module: pbm_regs
// Holds the control register, the mask register and the expected keys, and
// produces the registered read data. Assumes the error and status registers
// live in the capture unit and arrive here only for read-back.
module pbm_regs
    import pbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_KEYS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [SAMPLE_W-1:0]          wr_data,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         status_bit,
    input  logic [SAMPLE_W-1:0]          biterr,
    output logic                         chk_en,
    output logic                         alm_en,
    output logic                         mask_bit,
    output logic [NUM_KEYS*SAMPLE_W-1:0] keys_flat,
    output logic [SAMPLE_W-1:0]          rd_data
);
    logic [1:0]          ctrl_q;
    logic                mask_q;
    logic [SAMPLE_W-1:0] rd_mux;
    logic [SAMPLE_W-1:0] rd_q;

    // Control register: check enable and alarm output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(REG_CTRL))
            ctrl_q <= {wr_data[CTRL_ALM_BIT], wr_data[CTRL_CHK_BIT]};
    end

    // Mask register: alarm masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b1;
        else if (wr_en && wr_addr == ADDR_W'(REG_MASK))
            mask_q <= wr_data[0];
    end

    // One register per expected key, each decoded at its own address.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic [SAMPLE_W-1:0] key_q;
        // Load key k on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                key_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(KEY_BASE + k))
                key_q <= wr_data;
        end
        assign keys_flat[k*SAMPLE_W +: SAMPLE_W] = key_q;
    end

    // Read selection; unused addresses and bits give zero.
    always_comb begin
        rd_mux = '0;
        if (rd_addr == ADDR_W'(REG_CTRL))
            rd_mux[1:0] = ctrl_q;
        else if (rd_addr == ADDR_W'(REG_STATUS))
            rd_mux[0] = status_bit;
        else if (rd_addr == ADDR_W'(REG_MASK))
            rd_mux[0] = mask_q;
        else if (rd_addr == ADDR_W'(REG_BITERR))
            rd_mux = biterr;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (rd_addr == ADDR_W'(KEY_BASE + k))
                rd_mux = keys_flat[k*SAMPLE_W +: SAMPLE_W];
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= rd_mux;
    end

    assign chk_en   = ctrl_q[CTRL_CHK_BIT];
    assign alm_en   = ctrl_q[CTRL_ALM_BIT];
    assign mask_bit = mask_q;
    assign rd_data  = rd_q;
endmodule

// File: rtl/pbm_sequencer.sv
// Module: pbm_sequencer
// Tracks which key the current sample belongs to. A frame pulse forces slot
// 0, the slot advances on every compared sample and wraps after the last
// key. Assumes frame is only meaningful together with valid.
module pbm_sequencer #(
    parameter int NUM_KEYS = 8,
    localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             smp_valid,
    input  logic             smp_frame,
    output logic [IDX_W-1:0] slot,
    output logic             cmp_go
);
    logic [IDX_W-1:0] idx_q;
    logic             aligned_q;

    // Slot of the sample on the bus this cycle.
    always_comb begin
        slot   = smp_frame ? '0 : idx_q;
        cmp_go = chk_en && smp_valid && (smp_frame || aligned_q);
    end

    // Advance the key index and track alignment to the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !chk_en) begin
            idx_q     <= '0;
            aligned_q <= 1'b0;
        end else if (cmp_go) begin
            aligned_q <= 1'b1;
            idx_q     <= (slot == IDX_W'(NUM_KEYS - 1)) ? '0 : slot + 1'b1;
        end
    end
endmodule

// File: rtl/pbm_capture.sv
// Module: pbm_capture
// Compares a sample with its key and keeps the sticky per-bit error register
// and the pattern status alarm. A software write keeps only bits written as
// one; a hardware error in the same cycle still sets its bits.
module pbm_capture
    import pbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_KEYS = 8,
    parameter int ADDR_W   = 4,
    localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [SAMPLE_W-1:0]          wr_data,
    input  logic                         cmp_go,
    input  logic [IDX_W-1:0]             slot,
    input  logic [SAMPLE_W-1:0]          smp_data,
    input  logic [NUM_KEYS*SAMPLE_W-1:0] keys_flat,
    output logic [SAMPLE_W-1:0]          err_vec,
    output logic [SAMPLE_W-1:0]          biterr,
    output logic                         status_bit
);
    logic [SAMPLE_W-1:0] key_sel;
    logic [SAMPLE_W-1:0] biterr_q;
    logic                status_q;
    logic                wr_biterr;
    logic                wr_status;

    // Pick the key of this slot and form the per-bit mismatch.
    always_comb begin
        key_sel   = keys_flat[slot*SAMPLE_W +: SAMPLE_W];
        err_vec   = cmp_go ? (smp_data ^ key_sel) : '0;
        wr_biterr = wr_en && wr_addr == ADDR_W'(REG_BITERR);
        wr_status = wr_en && wr_addr == ADDR_W'(REG_STATUS);
    end

    // Sticky per-bit error capture; error bits win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            biterr_q <= '0;
        else
            biterr_q <= (wr_biterr ? (biterr_q & wr_data) : biterr_q) | err_vec;
    end

    // Sticky pattern alarm status; an error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else
            status_q <= (wr_status ? (status_q & wr_data[0]) : status_q) | (|err_vec);
    end

    assign biterr     = biterr_q;
    assign status_bit = status_q;
endmodule

// File: rtl/pbm_alarm.sv
// Module: pbm_alarm
// Registered alarm output: any status alarm that is set and not masked
// drives the output while the output enable is on. Assumes equal-width
// status and mask vectors.
module pbm_alarm #(
    parameter int NUM_ALARMS = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alm_en,
    input  logic [NUM_ALARMS-1:0] status,
    input  logic [NUM_ALARMS-1:0] mask,
    output logic                  alarm_out
);
    logic alarm_q;

    // Register the gated OR of unmasked status alarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= 1'b0;
        else
            alarm_q <= alm_en && (|(status & ~mask));
    end

    assign alarm_out = alarm_q;
endmodule

// File: rtl/bus_pattern_monitor.sv
// Module: bus_pattern_monitor (top)
// Checks a parallel sample bus against eight programmable keys that are
// aligned by a frame pulse. It keeps sticky bit errors and a status alarm,
// and gates the alarm to a pin through a mask and an output enable. Assumes
// a synchronous active-low reset and one sample per clock at most.
module bus_pattern_monitor #(
    parameter int SAMPLE_W = 16,
    parameter int NUM_KEYS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    input  logic                smp_valid,
    input  logic                smp_frame,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                alarm_out
);
    localparam int IDX_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

    logic                         chk_en;
    logic                         alm_en;
    logic                         mask_bit;
    logic                         status_bit;
    logic                         cmp_go;
    logic [IDX_W-1:0]             slot;
    logic [SAMPLE_W-1:0]          err_vec;
    logic [SAMPLE_W-1:0]          biterr;
    logic [NUM_KEYS*SAMPLE_W-1:0] keys_flat;

    pbm_regs #(.SAMPLE_W(SAMPLE_W), .NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .status_bit(status_bit), .biterr(biterr),
        .chk_en(chk_en), .alm_en(alm_en), .mask_bit(mask_bit),
        .keys_flat(keys_flat), .rd_data(rd_data)
    );

    pbm_sequencer #(.NUM_KEYS(NUM_KEYS)) u_seq (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .smp_valid(smp_valid), .smp_frame(smp_frame),
        .slot(slot), .cmp_go(cmp_go)
    );

    pbm_capture #(.SAMPLE_W(SAMPLE_W), .NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_go(cmp_go), .slot(slot), .smp_data(smp_data),
        .keys_flat(keys_flat),
        .err_vec(err_vec), .biterr(biterr), .status_bit(status_bit)
    );

    pbm_alarm #(.NUM_ALARMS(1)) u_alm (
        .clk(clk), .rst_n(rst_n), .alm_en(alm_en),
        .status(status_bit), .mask(mask_bit),
        .alarm_out(alarm_out)
    );
endmodule

// File: rtl/pbm_checker.sv
// Module: pbm_checker
// Cycle-by-cycle rules for the pattern checker, attached to the top module
// by the bind statement at the end of this file.
module pbm_checker
    import pbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                chk_en,
    input logic                alm_en,
    input logic                mask_bit,
    input logic                status_bit,
    input logic [SAMPLE_W-1:0] err_vec,
    input logic [SAMPLE_W-1:0] biterr,
    input logic                alarm_out
);
    logic wr_be;
    assign wr_be = wr_en && wr_addr == ADDR_W'(REG_BITERR);

    // R4: error bits only fall after a write to the error register
    assert_biterr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_be |=> ((biterr & $past(biterr)) == $past(biterr)));

    // R10: every mismatching bit is set next cycle, even under a clear
    assert_err_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_vec) |=> ((biterr & $past(err_vec)) == $past(err_vec)));

    // R6: any mismatch raises the status alarm
    assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_vec) |=> status_bit);

    // R2: no comparison while checking is disabled
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> (err_vec == '0));

    // R8: output disabled keeps the pin low
    assert_out_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_en |=> !alarm_out);

    // R7: a masked alarm never reaches the pin
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |=> !alarm_out);

    // R11: the pin only rises from an unmasked, enabled status alarm
    assert_out_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_out |-> $past(status_bit && !mask_bit && alm_en));
endmodule

bind bus_pattern_monitor pbm_checker #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .chk_en(chk_en), .alm_en(alm_en), .mask_bit(mask_bit),
    .status_bit(status_bit), .err_vec(err_vec), .biterr(biterr),
    .alarm_out(alarm_out)
);

// File: tb/bus_pattern_monitor_tb.sv
`timescale 1ns/1ps
module bus_pattern_monitor_tb;
    localparam int W  = 16;
    localparam int NK = 8;
    localparam int AW = 4;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          smp_valid = 1'b0;
    logic          smp_frame = 1'b0;
    logic [W-1:0]  smp_data = '0;
    logic          alarm_out;

    int       n_checks = 0;
    int       n_errors = 0;
    logic     rd_seen = 1'b0;
    rd_item_t rd_q[$];

    always #4 clk = ~clk;

    bus_pattern_monitor #(.SAMPLE_W(W), .NUM_KEYS(NK), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .smp_valid(smp_valid), .smp_frame(smp_frame),
        .smp_data(smp_data), .alarm_out(alarm_out)
    );

    function automatic logic [W-1:0] key_of(int k);
        return W'((k + 1) * 16'h1357) ^ 16'hC3A0;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(int a, logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(int a, logic [W-1:0] e, string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send(logic [W-1:0] d, logic fr);
        smp_valid = 1'b1; smp_frame = fr; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0; smp_frame = 1'b0;
    endtask

    // n samples of the key loop from slot 0; one slot may carry flipped bits
    task automatic burst(bit with_frame, int n, int bad_slot, logic [W-1:0] flip);
        for (int i = 0; i < n; i++) begin
            send(key_of(i % NK) ^ ((i == bad_slot) ? flip : '0),
                 with_frame && (i == 0));
        end
    endtask

    // Monitor: mark reads taken at the clock edge
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: pop the expected item and compare with the read data
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_q.size() == 0) begin
                check("R12 unexpected read", rd_data, '0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    initial begin
        #(8ns * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 alarm_out reset", W'(alarm_out), '0);
        reg_rd(0, 16'h0000, "R13 CTRL reset");
        reg_rd(1, 16'h0000, "R13 STATUS reset");
        reg_rd(2, 16'h0001, "R13 MASK reset");
        reg_rd(3, 16'h0000, "R13 BITERR reset");
        reg_rd(8 + 5, 16'h0000, "R13 key reset");

        // R1 key programming and read-back
        for (int k = 0; k < NK; k++) reg_wr(8 + k, key_of(k));
        reg_rd(8 + 3, key_of(3), "R1 key3 readback");
        reg_rd(8 + 7, key_of(7), "R1 key7 readback");
        reg_rd(4, 16'h0000, "R12 unused address");

        // R2 disabled: corrupt traffic ignored
        burst(1'b1, 8, 2, 16'hFFFF);
        reg_rd(3, 16'h0000, "R2 disabled no biterr");
        reg_rd(1, 16'h0000, "R2 disabled no status");

        // R2 enabled but not yet framed: wrong data ignored
        reg_wr(0, 16'h0001);
        send(16'h0BAD, 1'b0);
        send(16'h1BAD, 1'b0);
        reg_rd(3, 16'h0000, "R2 no compare before frame");

        // R3 correct order with wrap over two loops, one frame only
        burst(1'b1, 2 * NK, -1, '0);
        reg_rd(3, 16'h0000, "R3 ordered keys with wrap");

        // R3 check wrap: frame, then 8 plus slot 2 corrupted after wrap
        burst(1'b1, NK + 3, NK + 2, 16'h0010);
        reg_rd(3, 16'h0010, "R3 wrap slot 2 error bit");
        reg_wr(3, 16'h0000);
        reg_wr(1, 16'h0000);

        // R4 and R6 single bit error in slot 5, then sticky
        burst(1'b1, NK, 5, 16'h0040);
        reg_rd(3, 16'h0040, "R4 error bit captured");
        reg_rd(1, 16'h0001, "R6 status set");
        burst(1'b1, NK, -1, '0);
        reg_rd(3, 16'h0040, "R4 error bit sticky");
        reg_rd(1, 16'h0001, "R6 status sticky");

        // R5 write ones keeps, write zero clears
        reg_wr(3, 16'hFFFF);
        reg_rd(3, 16'h0040, "R5 write ones keeps biterr");
        reg_wr(3, 16'h0000);
        reg_rd(3, 16'h0000, "R5 write zero clears biterr");
        reg_wr(1, 16'h0001);
        reg_rd(1, 16'h0001, "R5 write one keeps status");
        reg_wr(1, 16'h0000);
        reg_rd(1, 16'h0000, "R5 write zero clears status");

        // R9 resync: partial loop, then a new frame mid-sequence
        burst(1'b1, 3, -1, '0);
        burst(1'b1, NK, -1, '0);
        reg_rd(3, 16'h0000, "R9 frame resyncs to key 0");

        // R10 same-cycle clear and mismatch (sequence at slot 0)
        reg_wr(3, 16'hFFFF);
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = 16'h0000;
        smp_valid = 1'b1; smp_frame = 1'b1; smp_data = key_of(0) ^ 16'h8001;
        @(negedge clk);
        wr_en = 1'b0; smp_valid = 1'b0; smp_frame = 1'b0;
        reg_rd(3, 16'h8001, "R10 error wins over clear");
        reg_rd(1, 16'h0001, "R10 status set");

        // R8 output disabled while status set and unmasked later
        check("R8 output disabled", W'(alarm_out), '0);
        reg_wr(0, 16'h0003);
        @(negedge clk);
        check("R7 masked keeps pin low", W'(alarm_out), '0);
        reg_rd(1, 16'h0001, "R7 status pollable while masked");

        // R11 unmask: pin rises one clock after the mask write takes effect
        reg_wr(2, 16'h0000);
        check("R11 pin not yet high", W'(alarm_out), '0);
        @(negedge clk);
        check("R11 pin high", W'(alarm_out), 16'h0001);

        // R8 output enable off drops the pin
        reg_wr(0, 16'h0001);
        @(negedge clk);
        check("R8 enable off drops pin", W'(alarm_out), '0);
        reg_wr(0, 16'h0003);
        @(negedge clk);
        check("R11 pin high again", W'(alarm_out), 16'h0001);

        // R11 clearing status drops the pin
        reg_wr(1, 16'h0000);
        @(negedge clk);
        check("R11 status clear drops pin", W'(alarm_out), '0);
        reg_rd(0, 16'h0003, "R12 CTRL readback");

        repeat (3) @(negedge clk);
        check("R12 all reads answered", W'(rd_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule